// File: doc/BRIEF.md
# Addressable LED pulse encoder

This block drives the data input of a daisy chain of intelligent RGB LED drivers. Each pixel colour arrives as a 24-bit word on a valid/ready stream with a marker for the final pixel of a frame. The block serialises every word most significant bit first. Each bit goes out as a high pulse followed by a low period, and the split between the two encodes a 0 or a 1. When the frame ends, the block holds the line low for a latch interval so that the chain shows the new colours. Nothing is read back from the chain.

All pulse lengths are cycle counts. They are computed at elaboration from the `CLK_HZ` parameter by rounding to the nearest cycle, and an elaboration-time check confirms that each rounded length lies within the allowed error.

Back-pressure rules:
- `in_ready` is high while idle.
- During a frame, `in_ready` is high only in the final cycle of the last bit's low period, and only if the current pixel did not carry the last marker.
- A word is taken on any rising edge where `in_valid` and `in_ready` are both high.
- While `in_ready` is low, the inputs are ignored.

Top module: `led_pulse_tx`

## Requirements
- R1: After reset, and whenever idle, `led_out` is 0, `busy` is 0 and `in_ready` is 1.
- R2: A 0 bit is a high level of round(0.4 µs·CLK_HZ) cycles followed by a low level of round(0.85 µs·CLK_HZ) cycles.
- R3: A 1 bit is a high level of round(0.8 µs·CLK_HZ) cycles followed by a low level of round(0.45 µs·CLK_HZ) cycles.
- R4: Every rounded bit duration is within ±150 ns of its nominal value. The latch interval is round(60 µs·CLK_HZ) cycles, which is more than 50 µs.
- R5: The bits of each word go out from bit 23 down to bit 0. Bits [23:16] are green, [15:8] red and [7:0] blue.
- R6: If the current pixel was not marked last, `in_ready` is 1 in the final low cycle of its bit 0. A word accepted in that cycle starts its first high pulse on the very next cycle, with no gap.
- R7: After the final low cycle of a pixel marked last, the line stays low for the latch interval. Throughout that interval `in_ready` is 0 and `busy` is 1, and the block then returns to idle.
- R8: If no word is valid in the final low cycle of an unmarked pixel, the block runs the latch interval exactly as in R7.
- R9: `busy` is 1 from the cycle after a word is accepted in idle until the latch interval has completed.
- R10: Changes on `in_valid`, `in_data` and `in_last` while `in_ready` is 0 do not alter the output waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel word offered |
| in_ready | output | 1 | Pixel word can be taken this cycle |
| in_data | input | PIX_W | Pixel colour, green-red-blue, MSB first |
| in_last | input | 1 | Offered word is the final pixel of the frame |
| led_out | output | 1 | Serial pulse line to the LED chain |
| busy | output | 1 | Frame or latch interval in progress |

## Verification
The critical cycle is the final low cycle of a pixel. In that cycle the end of the current bit sequence, the acceptance of the next word and the choice between continuing and latching all fall together. The bench provokes it three ways: back-to-back frames where the next word is offered exactly there, a frame that ends with the last marker, and a frame whose source simply stops. It judges every cycle of each frame against pulse lengths and ready/busy values computed from the requirements, while driving junk on the inputs whenever ready is low.

// File: rtl/led_tx_pkg.sv
package led_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HIGH  = 2'd1,
    ST_LOW   = 2'd2,
    ST_LATCH = 2'd3
  } tx_state_t;

  // nearest whole cycle count for a duration in nanoseconds
  function automatic int ns_to_cycles(input longint hz, input longint ns);
    return int'((hz * ns + 64'd500_000_000) / 64'd1_000_000_000);
  endfunction

  // true when cycles/hz lies within tol_ns of ns
  function automatic bit in_window(input longint hz, input longint cycles,
                                   input longint ns, input longint tol_ns);
    longint diff;
    diff = cycles * 64'd1_000_000_000 - ns * hz;
    if (diff < 0) diff = -diff;
    return (diff <= tol_ns * hz) && (cycles >= 1);
  endfunction

endpackage

// File: rtl/led_tx_timer.sv
module led_tx_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R2 R3: a running phase loses exactly one cycle per clock
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/led_tx_shifter.sv
module led_tx_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] d_in,
  output logic         cur_bit,
  output logic         nxt_bit,
  output logic         last_bit
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sr_q  <= d_in;
      idx_q <= '0;
    end else if (shift) begin
      sr_q  <= {sr_q[W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = sr_q[W-1];
  assign nxt_bit  = sr_q[W-2];
  assign last_bit = (idx_q == LAST_IDX);

  // R5: first bit on the line is the word's top bit
  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_bit == $past(d_in[W-1])));
  // R5: each shift advances exactly one bit position
  a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/led_pulse_tx.sv
module led_pulse_tx #(
  parameter int CLK_HZ = 50_000_000,
  parameter int PIX_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_last,
  output logic             led_out,
  output logic             busy
);
  import led_tx_pkg::*;

  localparam int T0H  = ns_to_cycles(CLK_HZ, 400);
  localparam int T0L  = ns_to_cycles(CLK_HZ, 850);
  localparam int T1H  = ns_to_cycles(CLK_HZ, 800);
  localparam int T1L  = ns_to_cycles(CLK_HZ, 450);
  localparam int TRST = ns_to_cycles(CLK_HZ, 60000);
  localparam int CW   = $clog2(TRST + 1);

  localparam logic [CW-1:0] H0_M1 = CW'(T0H - 1);
  localparam logic [CW-1:0] L0_M1 = CW'(T0L - 1);
  localparam logic [CW-1:0] H1_M1 = CW'(T1H - 1);
  localparam logic [CW-1:0] L1_M1 = CW'(T1L - 1);
  localparam logic [CW-1:0] RS_M1 = CW'(TRST - 1);

  // R4: rounding at this clock keeps every duration inside the window
  initial begin
    a_r4_timing_window: assert (in_window(CLK_HZ, T0H, 400, 150) &&
                                in_window(CLK_HZ, T0L, 850, 150) &&
                                in_window(CLK_HZ, T1H, 800, 150) &&
                                in_window(CLK_HZ, T1L, 450, 150) &&
                                (longint'(TRST) * 64'd1_000_000_000 >
                                 64'd50_000 * longint'(CLK_HZ)))
      else $error("pulse timing cannot be met at CLK_HZ=%0d", CLK_HZ);
  end

  tx_state_t     state_q, state_d;
  logic          last_q;
  logic          tm_load, tm_done;
  logic [CW-1:0] tm_val;
  logic          sh_load, sh_shift, cur_bit, nxt_bit, sh_last;
  logic          final_low, accept;

  led_tx_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .done(tm_done)
  );

  led_tx_shifter #(.W(PIX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_shift), .d_in(in_data),
    .cur_bit(cur_bit), .nxt_bit(nxt_bit), .last_bit(sh_last)
  );

  assign final_low = (state_q == ST_LOW) && tm_done && sh_last;
  assign in_ready  = (state_q == ST_IDLE) || (final_low && !last_q);
  assign accept    = in_valid && in_ready;

  always_comb begin
    state_d  = state_q;
    tm_load  = 1'b0;
    tm_val   = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_HIGH;
        sh_load = 1'b1;
        tm_load = 1'b1;
        tm_val  = in_data[PIX_W-1] ? H1_M1 : H0_M1;
      end
      ST_HIGH: if (tm_done) begin
        state_d = ST_LOW;
        tm_load = 1'b1;
        tm_val  = cur_bit ? L1_M1 : L0_M1;
      end
      ST_LOW: if (tm_done) begin
        tm_load = 1'b1;
        if (!sh_last) begin
          state_d  = ST_HIGH;
          sh_shift = 1'b1;
          tm_val   = nxt_bit ? H1_M1 : H0_M1;
        end else if (accept) begin
          state_d = ST_HIGH;
          sh_load = 1'b1;
          tm_val  = in_data[PIX_W-1] ? H1_M1 : H0_M1;
        end else begin
          state_d = ST_LATCH;
          tm_val  = RS_M1;
        end
      end
      ST_LATCH: if (tm_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) last_q <= in_last;
    end
  end

  assign led_out = (state_q == ST_HIGH);
  assign busy    = (state_q != ST_IDLE);

  // R1: an idle line rests low
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !led_out);
  // R9: acceptance from idle raises busy
  a_r9_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !busy) |=> busy);
  // R7: latch interval keeps the line low and refuses data
  a_r7_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LATCH) |-> (!led_out && !in_ready && busy));
  // R6: a word taken at the end of a pixel drives high on the next cycle
  a_r6_gapless: assert property (@(posedge clk) disable iff (!rst_n)
    (final_low && accept) |=> led_out);
  // R8: a pixel that ends without a new word goes to the latch interval
  a_r8_starve_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (final_low && !in_valid) |=> (state_q == ST_LATCH));
endmodule

// File: tb/led_pulse_tx_bench.sv
module led_pulse_tx_bench;
  localparam int CLK_HZ = 20_000_000;
  localparam int W      = 24;

  function automatic int cyc(input longint ns);
    return int'((ns * CLK_HZ + 64'd500_000_000) / 64'd1_000_000_000);
  endfunction

  localparam int H0  = cyc(400);
  localparam int L0  = cyc(850);
  localparam int H1  = cyc(800);
  localparam int L1  = cyc(450);
  localparam int RST = cyc(60000);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_last, led_out, busy;
  logic [W-1:0] in_data;

  always #5 clk = ~clk;

  led_pulse_tx #(.CLK_HZ(CLK_HZ), .PIX_W(W)) u_led_pulse_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .led_out(led_out), .busy(busy)
  );

  int vectors = 0;
  int errors  = 0;
  int junk_c  = 0;
  logic [W-1:0] pix [0:31];

  task automatic chk(input logic el, input logic eb, input logic er, input string req);
    vectors++;
    if (led_out !== el || busy !== eb || in_ready !== er) begin
      errors++;
      $display("FAIL %s: led/busy/ready actual %b%b%b expected %b%b%b at %0t",
               req, led_out, busy, in_ready, el, eb, er, $time);
    end
  endtask

  task automatic chk_val(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R10: garbage on the inputs while ready is low
  task automatic junk();
    junk_c++;
    in_valid = junk_c[0];
    in_last  = junk_c[1];
    in_data  = 24'h5A5A5A ^ W'(junk_c * 7919);
  endtask

  task automatic run_frame(input int n, input bit starve);
    string tag;
    @(negedge clk);
    chk(1'b0, 1'b0, 1'b1, "R1 idle before frame");
    in_valid = 1'b1;
    in_data  = pix[0];
    in_last  = (n == 1) && !starve;
    for (int p = 0; p < n; p++) begin
      for (int b = W - 1; b >= 0; b--) begin
        logic bt;
        int h, l;
        bt = pix[p][b];
        h  = bt ? H1 : H0;
        l  = bt ? L1 : L0;
        for (int i = 0; i < h; i++) begin
          @(negedge clk);
          chk(1'b1, 1'b1, 1'b0, bt ? "R3 R5 R10 one high" : "R2 R5 R10 zero high");
          junk();
        end
        for (int i = 0; i < l; i++) begin
          logic er;
          er = (b == 0) && (i == l - 1) && !((p == n - 1) && !starve);
          @(negedge clk);
          chk(1'b0, 1'b1, er, er ? "R6 ready at pixel end" :
                                 (bt ? "R3 R5 one low" : "R2 R5 zero low"));
          if (er) begin
            if (p + 1 < n) begin
              in_valid = 1'b1;
              in_data  = pix[p+1];
              in_last  = (p + 1 == n - 1) && !starve;
            end else begin
              in_valid = 1'b0;
            end
          end else begin
            junk();
          end
        end
      end
    end
    tag = starve ? "R8 latch after starvation" : "R7 latch after last";
    for (int i = 0; i < RST; i++) begin
      @(negedge clk);
      chk(1'b0, 1'b1, 1'b0, tag);
      junk();
    end
    @(negedge clk);
    chk(1'b0, 1'b0, 1'b1, "R9 R1 idle after latch");
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(1'b0, 1'b0, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, 1'b0, 1'b1, "R1 after reset");

    // R4: tolerance window and latch length from the bench's own counts
    chk_val((H0 * 50 >= 250) && (H0 * 50 <= 550), "R4 zero high", H0 * 50, 400);
    chk_val((L0 * 50 >= 700) && (L0 * 50 <= 1000), "R4 zero low", L0 * 50, 850);
    chk_val((H1 * 50 >= 650) && (H1 * 50 <= 950), "R4 one high", H1 * 50, 800);
    chk_val((L1 * 50 >= 300) && (L1 * 50 <= 600), "R4 one low", L1 * 50, 450);
    chk_val(RST * 50 > 50000, "R4 latch length", RST * 50, 60000);

    pix[0] = 24'hFFFFFF;
    run_frame(1, 1'b0);

    pix[0] = 24'h000000; pix[1] = 24'hA5C30F; pix[2] = 24'h5A3CF0;
    run_frame(3, 1'b0);

    for (int k = 0; k < W; k++) pix[k] = W'(1) << k;
    run_frame(W, 1'b0);

    pix[0] = 24'h123456; pix[1] = 24'hFEDCBA;
    run_frame(2, 1'b1);

    for (int k = 0; k < W; k++) pix[k] = ~(W'(1) << (W - 1 - k));
    run_frame(4, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule